// File: doc/BRIEF.md
# DMA Bus Master Control Signal Generator

This block produces the control lines that a DMA bus master drives on a multiplexed 16-bit address/data bus. It takes a start pulse and transfer description from an internal DMA engine, arbitrates for the bus against a hold acknowledge input, and then runs one transaction. A transaction is a single address-phase cycle followed by data-phase cycles, and it ends on a done strobe from the engine. Every bus line comes with its own output-enable, so the pads can be tri-stated whenever the block is not bus master.

Two configuration bits select the signalling style at run time. The first bit picks one of two schemes. In the first scheme the block drives a two-bit byte mask and a HOLD-style request that ignores the pin history. In the second it drives a BYTE line, with the lane taken from address bit 0, a bus request that only fires when the shared request pin was seen high, and a daisy-chained grant pass-through on the second byte pin. The second configuration bit sets the polarity of the address strobe. A third bit enables 8-bit operation; without it every transfer is a whole word. Configuration is sampled only while the block is idle, so a change made during a transaction never alters it half-way.

Top module: `dma_bus_ctrl`

## Requirements
- R1: After reset, req_n_o is 1, strobe_oe_o, bsel0_oe_o and bsel1_oe_o are 0, and err_o is 0.
- R2: With cfg_byte_mode_i=0, a legal start pulse drives req_n_o low on the second rising edge after the pulse is sampled, as long as hlda_n_i is 1. The level of busrq_pin_n_i has no effect.
- R3: With cfg_byte_mode_i=1, a pending request drives req_n_o low only at an edge where busrq_pin_n_i is sampled 1 and hlda_n_i is 1. While busrq_pin_n_i is 0, req_n_o stays 1.
- R4: hlda_n_i sampled 0 while requesting makes the block bus master at the next edge: strobe_oe_o and bsel0_oe_o go to 1. The address phase lasts exactly one cycle, and the data phase lasts until xfer_done_i is sampled 1. At the edge that samples done, req_n_o returns to 1 and all bus-master enables drop to 0. req_n_o stays 0 for the whole transaction.
- R5: With cfg_strobe_inv_i=0, strobe_o is 1 in the address phase and 0 in the data phase. With cfg_strobe_inv_i=1, both levels are inverted.
- R6: With cfg_byte_mode_i=0, {bsel1_o,bsel0_o} equals the size code while master: 00 whole word, 01 upper byte, 10 lower byte, 11 no byte. The xfer_size_i code uses the same values.
- R7: With cfg_byte_mode_i=1, bsel0_o is the BYTE line while master. It is 0 for a word and 1 for either byte size; the lane is chosen by xfer_a0_i alone.
- R8: With cfg_byte_mode_i=1, a start whose effective size is a word at xfer_a0_i=1, or whose size code is 11, sets err_o at the next edge. No request is made for it (req_n_o stays 1). err_o stays 1 until reset.
- R9: With cfg_byte_mode_i=1, bsel1_oe_o is 1 at all times, and bsel1_o is a grant pass-through. At each edge it becomes 0 if hlda_n_i is 0 while req_n_o is 1; otherwise it becomes 1. With cfg_byte_mode_i=0, bsel1_oe_o is 0 when not master.
- R10: With cfg_narrow_i=0, every transfer is a whole word whatever xfer_size_i holds.
- R11: Configuration inputs take effect only at an edge where the block is idle. A change made during a transaction does not alter that transaction's outputs; it applies to the next one.
- R12: While hlda_n_i is 0, a pending request waits with req_n_o at 1, and it asserts req_n_o at the edge after hlda_n_i returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_byte_mode_i | input | 1 | 0: byte mask and HOLD; 1: BYTE/A0, bus request, grant chain |
| cfg_strobe_inv_i | input | 1 | 0: strobe high in address phase; 1: inverted |
| cfg_narrow_i | input | 1 | 1: 8-bit operation allows byte sizes |
| xfer_start_i | input | 1 | One-cycle start pulse from the DMA engine |
| xfer_size_i | input | 2 | 00 word, 01 upper, 10 lower, 11 none |
| xfer_a0_i | input | 1 | Bit 0 of the transfer address |
| xfer_done_i | input | 1 | Ends the data phase |
| hlda_n_i | input | 1 | Hold acknowledge, active low |
| busrq_pin_n_i | input | 1 | Sampled level of the shared request pin |
| req_n_o | output | 1 | Bus request, active low (open-drain style) |
| strobe_o | output | 1 | Address strobe |
| strobe_oe_o | output | 1 | Enable for strobe_o |
| bsel0_o | output | 1 | Mask bit 0 or BYTE line |
| bsel0_oe_o | output | 1 | Enable for bsel0_o |
| bsel1_o | output | 1 | Mask bit 1 or grant pass-through |
| bsel1_oe_o | output | 1 | Enable for bsel1_o |
| err_o | output | 1 | Sticky illegal-transfer flag |

## Verification
A sequencer stuck in the wrong state shows up at once on the outputs. A missed hold-acknowledge keeps the enables low one cycle after the bench grants the bus. A failure to leave the address phase leaves strobe_o at its address level in the following cycle, and a missing release keeps req_n_o low the cycle after done. A stale or wrongly latched configuration register shows up in the first transaction after the change, as the wrong strobe polarity, mask code or bsel1_oe_o level. A lost sticky error bit shows up as err_o falling while no reset is applied.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

  localparam int SZW = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARB, ST_REQ, ST_ADDR, ST_DATA, ST_REL
  } dbc_state_e;

  typedef enum logic [SZW-1:0] {
    SZ_WORD  = 2'b00,
    SZ_UPPER = 2'b01,
    SZ_LOWER = 2'b10,
    SZ_NONE  = 2'b11
  } dbc_size_e;

  typedef struct packed {
    logic byte_mode;
    logic strobe_inv;
    logic narrow;
  } dbc_cfg_t;

  function automatic logic dbc_illegal(input logic byte_mode, input dbc_size_e sz,
                                       input logic a0);
    return byte_mode && ((sz == SZ_NONE) || ((sz == SZ_WORD) && a0));
  endfunction

endpackage

// File: rtl/dbc_cfg_hold.sv
module dbc_cfg_hold
  import dbc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     idle_i,
  input  dbc_cfg_t cfg_i,
  output dbc_cfg_t cfg_q,
  output dbc_cfg_t cfg_d
);

  assign cfg_d = idle_i ? cfg_i : cfg_q;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_d;
  end

  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    !$past(idle_i) |-> $stable(cfg_q)); // R11

endmodule

// File: rtl/dbc_byte_enc.sv
module dbc_byte_enc
  import dbc_pkg::*;
(
  input  logic      byte_mode_i,
  input  dbc_size_e size_i,
  output logic      pin0_o,
  output logic      pin1_o
);

  always_comb begin
    if (byte_mode_i) begin
      pin0_o = (size_i != SZ_WORD);
      pin1_o = 1'b1;
    end else begin
      pin0_o = size_i[0];
      pin1_o = size_i[1];
    end
  end

endmodule

// File: rtl/dbc_seq.sv
module dbc_seq
  import dbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       byte_mode_i,
  input  logic       hlda_n_i,
  input  logic       pin_n_i,
  input  logic       done_i,
  output dbc_state_e st_q,
  output dbc_state_e st_n
);

  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_IDLE: if (start_i) st_n = ST_ARB;
      ST_ARB:  if (hlda_n_i && (!byte_mode_i || pin_n_i)) st_n = ST_REQ;
      ST_REQ:  if (!hlda_n_i) st_n = ST_ADDR;
      ST_ADDR: st_n = ST_DATA;
      ST_DATA: if (done_i) st_n = ST_REL;
      ST_REL:  st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_n;
  end

  AST_ADDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ADDR) |=> (st_q == ST_DATA)); // R4

endmodule

// File: rtl/dma_bus_ctrl.sv
module dma_bus_ctrl
  import dbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_byte_mode_i,
  input  logic       cfg_strobe_inv_i,
  input  logic       cfg_narrow_i,
  input  logic       xfer_start_i,
  input  logic [1:0] xfer_size_i,
  input  logic       xfer_a0_i,
  input  logic       xfer_done_i,
  input  logic       hlda_n_i,
  input  logic       busrq_pin_n_i,
  output logic       req_n_o,
  output logic       strobe_o,
  output logic       strobe_oe_o,
  output logic       bsel0_o,
  output logic       bsel0_oe_o,
  output logic       bsel1_o,
  output logic       bsel1_oe_o,
  output logic       err_o
);

  dbc_state_e st_q, st_n;
  dbc_cfg_t   cfg_in, cfg_q, cfg_d;
  dbc_size_e  eff_size, cmd_size;
  logic       cmd_a0, accept, bad, enc0, enc1, master_n, req_next;

  assign cfg_in   = '{byte_mode: cfg_byte_mode_i, strobe_inv: cfg_strobe_inv_i,
                      narrow: cfg_narrow_i};
  assign eff_size = cfg_q.narrow ? dbc_size_e'(xfer_size_i) : SZ_WORD;
  assign accept   = xfer_start_i && (st_q == ST_IDLE);
  assign bad      = dbc_illegal(cfg_q.byte_mode, eff_size, xfer_a0_i);

  dbc_cfg_hold u_cfg (
    .clk(clk), .rst(rst), .idle_i(st_q == ST_IDLE),
    .cfg_i(cfg_in), .cfg_q(cfg_q), .cfg_d(cfg_d)
  );

  dbc_seq u_seq (
    .clk(clk), .rst(rst), .start_i(accept && !bad),
    .byte_mode_i(cfg_q.byte_mode), .hlda_n_i(hlda_n_i),
    .pin_n_i(busrq_pin_n_i), .done_i(xfer_done_i),
    .st_q(st_q), .st_n(st_n)
  );

  dbc_byte_enc u_enc (
    .byte_mode_i(cfg_d.byte_mode), .size_i(cmd_size),
    .pin0_o(enc0), .pin1_o(enc1)
  );

  assign master_n = (st_n == ST_ADDR) || (st_n == ST_DATA);
  assign req_next = (st_n == ST_REQ) || master_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_size    <= SZ_WORD;
      cmd_a0      <= 1'b0;
      err_o       <= 1'b0;
      req_n_o     <= 1'b1;
      strobe_o    <= 1'b0;
      strobe_oe_o <= 1'b0;
      bsel0_o     <= 1'b1;
      bsel0_oe_o  <= 1'b0;
      bsel1_o     <= 1'b1;
      bsel1_oe_o  <= 1'b0;
    end else begin
      if (accept) begin
        cmd_size <= eff_size;
        cmd_a0   <= xfer_a0_i;
        if (bad) err_o <= 1'b1;
      end
      req_n_o     <= !req_next;
      strobe_oe_o <= master_n;
      strobe_o    <= master_n && ((st_n == ST_ADDR) ^ cfg_d.strobe_inv);
      bsel0_oe_o  <= master_n;
      bsel0_o     <= master_n ? enc0 : 1'b1;
      if (cfg_d.byte_mode) begin
        bsel1_oe_o <= 1'b1;
        bsel1_o    <= hlda_n_i || !req_n_o;
      end else begin
        bsel1_oe_o <= master_n;
        bsel1_o    <= master_n ? enc1 : 1'b1;
      end
    end
  end

  AST_MASTER_REQUESTS: assert property (@(posedge clk) disable iff (rst)
    strobe_oe_o |-> !req_n_o); // R4

  AST_STROBE_ADDR_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (strobe_oe_o && !$past(strobe_oe_o)) |-> (strobe_o != cfg_q.strobe_inv)); // R5

  AST_BUSRQ_PIN_FREE: assert property (@(posedge clk) disable iff (rst)
    ($fell(req_n_o) && cfg_q.byte_mode) |-> $past(busrq_pin_n_i)); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(err_o) |-> err_o); // R8

  AST_BYTE_A0_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
    (bsel0_oe_o && cfg_q.byte_mode && !bsel0_o) |-> !cmd_a0); // R8

endmodule

// File: tb/test_dma_bus_ctrl.sv
module test_dma_bus_ctrl;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_byte_mode_i = 0, cfg_strobe_inv_i = 0, cfg_narrow_i = 1;
  logic xfer_start_i = 0, xfer_a0_i = 0, xfer_done_i = 0;
  logic [1:0] xfer_size_i = 2'b00;
  logic hlda_n_i = 1, busrq_pin_n_i = 1;
  logic req_n_o, strobe_o, strobe_oe_o, bsel0_o, bsel0_oe_o, bsel1_o, bsel1_oe_o, err_o;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  dma_bus_ctrl i_dma_bus_ctrl (.*);

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  // Full transaction from idle with hlda_n_i=1 and the request pin free.
  task automatic run_xfer(input string req, input logic [1:0] sz, input logic a0,
                          input logic [1:0] exp_sel, input logic exp_addr,
                          input logic flip_cfg);
    xfer_start_i = 1; xfer_size_i = sz; xfer_a0_i = a0;
    nxt(); xfer_start_i = 0;
    check("R2", {3'b0, req_n_o}, 4'd1);
    nxt();
    check("R2", {3'b0, req_n_o}, 4'd0);
    check("R4", {3'b0, strobe_oe_o}, 4'd0);
    hlda_n_i = 0;
    nxt();
    check("R4", {2'b0, strobe_oe_o, bsel0_oe_o}, 4'b0011);
    check("R5", {3'b0, strobe_o}, {3'b0, exp_addr});
    check(req, {2'b0, bsel1_o, bsel0_o}, {2'b0, exp_sel});
    if (flip_cfg) cfg_strobe_inv_i = ~cfg_strobe_inv_i;
    nxt();
    check("R5", {3'b0, strobe_o}, {3'b0, ~exp_addr});
    nxt();
    check("R4", {2'b0, strobe_o, req_n_o}, {2'b0, ~exp_addr, 1'b0});
    xfer_done_i = 1;
    nxt(); xfer_done_i = 0;
    check("R4", {1'b0, req_n_o, strobe_oe_o, bsel0_oe_o}, 4'b0100);
    hlda_n_i = 1;
    nxt(); nxt();
  endtask

  task automatic t_reset();
    check("R1", {req_n_o, strobe_oe_o, bsel0_oe_o, bsel1_oe_o}, 4'b1000);
    check("R1", {3'b0, err_o}, 4'd0);
  endtask

  task automatic t_mask_mode();
    cfg_byte_mode_i = 0; cfg_strobe_inv_i = 0; cfg_narrow_i = 1;
    busrq_pin_n_i = 0;  // ignored in this mode
    nxt();
    run_xfer("R6", 2'b00, 0, 2'b00, 1, 0);
    run_xfer("R6", 2'b01, 1, 2'b01, 1, 0);
    run_xfer("R6", 2'b10, 0, 2'b10, 1, 0);
    run_xfer("R6", 2'b11, 0, 2'b11, 1, 0);
    check("R9", {3'b0, bsel1_oe_o}, 4'd0);
    busrq_pin_n_i = 1;
  endtask

  task automatic t_strobe_inv();
    cfg_strobe_inv_i = 1; nxt();
    run_xfer("R6", 2'b00, 0, 2'b00, 0, 0);
    cfg_strobe_inv_i = 0; nxt();
  endtask

  task automatic t_narrow();
    cfg_narrow_i = 0; nxt();
    run_xfer("R10", 2'b10, 0, 2'b00, 1, 0);
    cfg_narrow_i = 1; nxt();
  endtask

  task automatic t_byte_mode();
    cfg_byte_mode_i = 1; nxt();
    run_xfer("R7", 2'b00, 0, 2'b10, 1, 0);
    run_xfer("R7", 2'b01, 1, 2'b11, 1, 0);
    run_xfer("R7", 2'b10, 0, 2'b11, 1, 0);
    check("R9", {3'b0, bsel1_oe_o}, 4'd1);
  endtask

  task automatic t_busrq();
    busrq_pin_n_i = 0;
    xfer_start_i = 1; xfer_size_i = 2'b10; xfer_a0_i = 0;
    nxt(); xfer_start_i = 0;
    nxt(); check("R3", {3'b0, req_n_o}, 4'd1);
    nxt(); check("R3", {3'b0, req_n_o}, 4'd1);
    busrq_pin_n_i = 1;
    nxt(); check("R3", {3'b0, req_n_o}, 4'd0);
    hlda_n_i = 0;
    nxt(); check("R4", {3'b0, strobe_oe_o}, 4'd1);
    nxt(); xfer_done_i = 1;
    nxt(); xfer_done_i = 0;
    check("R4", {3'b0, req_n_o}, 4'd1);
    hlda_n_i = 1;
    nxt(); nxt();
  endtask

  task automatic t_daisy();
    hlda_n_i = 0;
    nxt(); check("R9", {2'b0, bsel1_oe_o, bsel1_o}, 4'b0010);
    hlda_n_i = 1;
    nxt(); check("R9", {2'b0, bsel1_oe_o, bsel1_o}, 4'b0011);
    cfg_byte_mode_i = 0; hlda_n_i = 0;
    nxt(); nxt();
    check("R9", {3'b0, bsel1_oe_o}, 4'd0);
    hlda_n_i = 1; cfg_byte_mode_i = 1;
    nxt(); nxt();
  endtask

  task automatic t_illegal();
    xfer_start_i = 1; xfer_size_i = 2'b00; xfer_a0_i = 1;
    nxt(); xfer_start_i = 0;
    check("R8", {2'b0, err_o, req_n_o}, 4'b0011);
    nxt(); nxt();
    check("R8", {3'b0, req_n_o}, 4'd1);
    xfer_start_i = 1; xfer_size_i = 2'b11; xfer_a0_i = 0;
    nxt(); xfer_start_i = 0;
    nxt(); nxt();
    check("R8", {2'b0, err_o, req_n_o}, 4'b0011);
    run_xfer("R7", 2'b00, 0, 2'b10, 1, 0);
    check("R8", {3'b0, err_o}, 4'd1);
  endtask

  task automatic t_cfg_change();
    cfg_byte_mode_i = 0; cfg_strobe_inv_i = 0; nxt();
    run_xfer("R11", 2'b01, 1, 2'b01, 1, 1);
    run_xfer("R11", 2'b01, 1, 2'b01, 0, 0);
    cfg_strobe_inv_i = 0; nxt();
  endtask

  task automatic t_hlda_busy();
    hlda_n_i = 0;
    xfer_start_i = 1; xfer_size_i = 2'b00; xfer_a0_i = 0;
    nxt(); xfer_start_i = 0;
    nxt(); check("R12", {3'b0, req_n_o}, 4'd1);
    nxt(); check("R12", {3'b0, req_n_o}, 4'd1);
    hlda_n_i = 1;
    nxt(); check("R12", {3'b0, req_n_o}, 4'd0);
    hlda_n_i = 0;
    nxt(); check("R12", {3'b0, strobe_oe_o}, 4'd1);
    nxt(); xfer_done_i = 1;
    nxt(); xfer_done_i = 0;
    hlda_n_i = 1;
    nxt(); nxt();
  endtask

  initial begin
    repeat (3) nxt();
    rst = 0;
    nxt();
    t_reset();
    t_mask_mode();
    t_strobe_inv();
    t_narrow();
    t_cfg_change();
    t_hlda_busy();
    t_byte_mode();
    t_busrq();
    t_daisy();
    t_illegal();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule